// File: doc/BRIEF.md
# Control-OUT Packet Receive Buffer

This block holds the data stage of control-OUT transfers on the default endpoint. A serial engine presents bytes one per cycle, qualified by a valid strobe and a setup-stage marker, and ends each packet with either a good end-of-packet strobe or an error end-of-packet strobe. Bytes that carry the setup marker never enter this buffer, because setup commands are kept somewhere else. When a good packet ends, the block latches the byte count into a size register. It then raises a completion flag and locks itself. While it is locked it reports busy (NAK) to the serial engine and drops all traffic.

Firmware reads the packet one byte per read strobe through a byte-wide port. The byte appears one cycle after the strobe. Firmware then writes a read-finished trigger to unlock the buffer for the next packet. The completion flag is write-1-to-clear and has no effect on the lock. A separate clear control empties the buffer and resets its pointers from any state. Packets that end in error, and packets longer than the storage, are discarded completely.

The control state machine has four states:
- IDLE: empty and ready.
  - A plain byte moves it to FILL.
  - A good end-of-packet moves it to HELD as a zero-length packet.
- FILL: collecting a packet.
  - A good end moves it to HELD.
  - An error end moves it to IDLE.
  - A byte that arrives while the storage is full moves it to DROP.
- DROP: discarding an overlong packet.
  - Either end strobe moves it to IDLE.
- HELD: locked.
  - The read-finished trigger moves it to IDLE.

The clear control forces IDLE from any state.

Top module: `ctl_out_rxbuf`

## Requirements
- R1: After reset, rx_nak, rx_done, rx_size and rd_byte are all zero.
- R2: Non-setup bytes are stored in arrival order. The cycle after a good end-of-packet, rx_size equals the byte count, rx_done is 1 and rx_nak is 1.
- R3: A byte or an end-of-packet strobe that arrives with rx_setup high has no effect on storage, size, flag or state.
- R4: While a packet is held, rx_nak stays 1. Incoming bytes and end-of-packet strobes are dropped, and the held size and data stay unchanged.
- R5: A rel_trig pulse while a packet is held returns the block to IDLE, with rx_nak 0 the next cycle. The next packet is stored from entry 0.
- R6: A packet that ends with rx_eop_err (alone or together with rx_eop_ok) is discarded. rx_done and rx_size keep their previous values.
- R7: rx_done is cleared by a done_clr pulse. Clearing it does not unlock the buffer. If a good end-of-packet and done_clr arrive in the same cycle, the flag ends up set.
- R8: A read strobe while unread bytes remain returns the next byte on rd_byte one cycle later and advances the read pointer. With no unread bytes it returns 0 and the pointer stays where it is.
- R9: buf_clr from any state returns the block to IDLE, sets rx_size to 0, resets both pointers and drops any packet in progress. rx_done is unaffected.
- R10: A packet with more bytes than the storage depth is discarded entirely, even if it ends good. Flag and size are unchanged.
- R11: A good end-of-packet with no bytes sets rx_done, sets rx_size to 0 and locks the buffer.
- R12: A byte strobe in the same cycle as an end-of-packet strobe is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Serial-engine byte strobe |
| rx_data | input | DW | Serial-engine byte |
| rx_setup | input | 1 | Marks the current byte or end strobe as setup stage |
| rx_eop_ok | input | 1 | Packet ended without error |
| rx_eop_err | input | 1 | Packet ended with error |
| rx_nak | output | 1 | Busy indication toward the serial engine (packet held) |
| rd_strobe | input | 1 | CPU data-port read strobe |
| rd_byte | output | DW | CPU read data, valid the cycle after the strobe |
| rx_size | output | clog2(DEPTH+1) | Byte count of the last good packet |
| rx_done | output | 1 | Receive-complete flag |
| done_clr | input | 1 | Write-1-to-clear pulse for rx_done |
| rel_trig | input | 1 | Read-finished trigger that unlocks the buffer |
| buf_clr | input | 1 | Empties the buffer and resets pointers |

## Verification
The bench builds the block with DEPTH set to 8 and DW left at 8. With that depth a packet that exactly fills the storage and a one-byte-longer packet that overruns into DROP each take only a handful of cycles. A small table of packets covers good, error, setup, empty and overrun endings, and every accepted packet is read back through the data port. Directed sequences then cover the same-cycle collisions: a set and a clear of the flag together, a byte with an end-of-packet strobe, and a clear during reception and during a held packet.

// File: rtl/ctl_rx_pkg.sv
package ctl_rx_pkg;
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_FILL = 2'd1,
        RX_DROP = 2'd2,
        RX_HELD = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
    import ctl_rx_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rx_setup,
    input  logic          rx_eop_ok,
    input  logic          rx_eop_err,
    input  logic          rel_trig,
    input  logic          buf_clr,
    input  logic          done_clr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [CW-1:0] size_q,
    output logic          done_q,
    output logic          held,
    output logic          ptr_rst
);
    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          eop_any, eop_good, eop_bad, byte_in, full;
    logic          accept, cnt_zero;

    // A setup-stage strobe never touches this buffer.
    assign eop_any  = (rx_eop_ok || rx_eop_err) && !rx_setup;
    assign eop_bad  = rx_eop_err && !rx_setup;
    assign eop_good = rx_eop_ok && !rx_eop_err && !rx_setup;
    // An end strobe takes precedence over a byte in the same cycle.
    assign byte_in  = rx_valid && !rx_setup && !(rx_eop_ok || rx_eop_err);
    assign full     = (cnt_q == CW'(DEPTH));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (eop_good)     state_d = RX_HELD;
                else if (byte_in) state_d = RX_FILL;
            end
            RX_FILL: begin
                if (eop_good)             state_d = RX_HELD;
                else if (eop_bad)         state_d = RX_IDLE;
                else if (byte_in && full) state_d = RX_DROP;
            end
            RX_DROP: begin
                if (eop_any) state_d = RX_IDLE;
            end
            RX_HELD: begin
                if (rel_trig) state_d = RX_IDLE;
            end
        endcase
        if (buf_clr) state_d = RX_IDLE;
    end

    // Output decode
    always_comb begin
        wr_en    = 1'b0;
        accept   = 1'b0;
        cnt_zero = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                wr_en  = byte_in;
                accept = eop_good;
            end
            RX_FILL: begin
                wr_en    = byte_in && !full;
                accept   = eop_good;
                cnt_zero = eop_bad;
            end
            RX_DROP: cnt_zero = eop_any;
            RX_HELD: cnt_zero = rel_trig;
        endcase
        if (buf_clr) begin
            wr_en    = 1'b0;
            accept   = 1'b0;
            cnt_zero = 1'b1;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (wr_en)    cnt_d = cnt_q + 1'b1;
        if (cnt_zero) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            size_q <= '0;
            done_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (buf_clr)     size_q <= '0;
            else if (accept) size_q <= cnt_q;
            if (accept)        done_q <= 1'b1;
            else if (done_clr) done_q <= 1'b0;
        end
    end

    assign wr_addr = cnt_q[AW-1:0];
    assign held    = (state_q == RX_HELD);
    assign ptr_rst = buf_clr || (held && rel_trig);

    // R4
    held_size_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_HELD && !buf_clr) |=> $stable(size_q));
    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    // R7
    done_rise_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> (state_q == RX_HELD));
    // R6
    err_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_FILL && eop_bad && !done_q) |=> !done_q);
    // R9
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clr |=> (state_q == RX_IDLE && size_q == '0));
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/rxbuf_reader.sv
module rxbuf_reader #(
    parameter int DW = 8,
    parameter int AW = 6,
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_strobe,
    input  logic          held,
    input  logic          ptr_rst,
    input  logic [CW-1:0] size_q,
    input  logic [DW-1:0] mem_data,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_byte
);
    logic [CW-1:0] rd_ptr_q;
    logic          avail, take;

    assign avail   = held && (rd_ptr_q < size_q);
    assign take    = rd_strobe && avail;
    assign rd_addr = rd_ptr_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q <= '0;
            rd_byte  <= '0;
        end else begin
            if (ptr_rst)   rd_ptr_q <= '0;
            else if (take) rd_ptr_q <= rd_ptr_q + 1'b1;
            if (rd_strobe) rd_byte <= take ? mem_data : '0;
        end
    end

    // R8
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !avail && !ptr_rst) |=> $stable(rd_ptr_q));
    // R8
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !avail) |=> (rd_byte == '0));
    // R8
    rd_ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_q <= size_q);
endmodule

// File: rtl/ctl_out_rxbuf.sv
module ctl_out_rxbuf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_valid,
    input  logic [DW-1:0]              rx_data,
    input  logic                       rx_setup,
    input  logic                       rx_eop_ok,
    input  logic                       rx_eop_err,
    output logic                       rx_nak,
    input  logic                       rd_strobe,
    output logic [DW-1:0]              rd_byte,
    output logic [$clog2(DEPTH+1)-1:0] rx_size,
    output logic                       rx_done,
    input  logic                       done_clr,
    input  logic                       rel_trig,
    input  logic                       buf_clr
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, held, ptr_rst;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [CW-1:0] size_q;
    logic [DW-1:0] mem_data;

    rxbuf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_setup   (rx_setup),
        .rx_eop_ok  (rx_eop_ok),
        .rx_eop_err (rx_eop_err),
        .rel_trig   (rel_trig),
        .buf_clr    (buf_clr),
        .done_clr   (done_clr),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .size_q     (size_q),
        .done_q     (rx_done),
        .held       (held),
        .ptr_rst    (ptr_rst)
    );

    rxbuf_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (rx_data),
        .rd_addr (rd_addr),
        .rd_data (mem_data)
    );

    rxbuf_reader #(.DW(DW), .AW(AW), .CW(CW)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .held      (held),
        .ptr_rst   (ptr_rst),
        .size_q    (size_q),
        .mem_data  (mem_data),
        .rd_addr   (rd_addr),
        .rd_byte   (rd_byte)
    );

    assign rx_nak  = held;
    assign rx_size = size_q;
endmodule

// File: tb/ctl_out_rxbuf_test.sv
module ctl_out_rxbuf_test;
    localparam int DEPTH = 8;
    localparam int DW    = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    // fields: [7:0] length, [8] error end, [9] setup stage, [10] accepted
    localparam logic [31:0] VECS [8] = '{
        32'h403, 32'h408, 32'h400, 32'h105,
        32'h204, 32'h009, 32'h401, 32'h102
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx_valid = 1'b0, rx_setup = 1'b0, rx_eop_ok = 1'b0, rx_eop_err = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          rd_strobe = 1'b0, done_clr = 1'b0, rel_trig = 1'b0, buf_clr = 1'b0;
    logic          rx_nak, rx_done;
    logic [DW-1:0] rd_byte;
    logic [CW-1:0] rx_size;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ctl_out_rxbuf #(.DEPTH(DEPTH), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_setup(rx_setup), .rx_eop_ok(rx_eop_ok), .rx_eop_err(rx_eop_err),
        .rx_nak(rx_nak), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
        .rx_size(rx_size), .rx_done(rx_done), .done_clr(done_clr),
        .rel_trig(rel_trig), .buf_clr(buf_clr)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic setup);
        rx_valid = 1'b1; rx_data = b; rx_setup = setup;
        @(negedge clk);
        rx_valid = 1'b0; rx_setup = 1'b0;
    endtask

    task automatic send_eop(input logic ok, input logic setup);
        rx_eop_ok = ok; rx_eop_err = !ok; rx_setup = setup;
        @(negedge clk);
        rx_eop_ok = 1'b0; rx_eop_err = 1'b0; rx_setup = 1'b0;
    endtask

    task automatic read_one(output logic [7:0] v);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        v = rd_byte;
    endtask

    task automatic pulse_done_clr();
        done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
    endtask

    task automatic pulse_rel();
        rel_trig = 1'b1; @(negedge clk); rel_trig = 1'b0;
    endtask

    task automatic pulse_clr();
        buf_clr = 1'b1; @(negedge clk); buf_clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] x;
        int last_size;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "nak", rx_nak, 0);
        chk("R1", "done", rx_done, 0);
        chk("R1", "size", rx_size, 0);
        chk("R1", "rd_byte", rd_byte, 0);

        // table of packets
        last_size = 0;
        for (int v = 0; v < 8; v++) begin
            int len, exp_size;
            logic err, setup, acc;
            string tag;
            len = int'(VECS[v][7:0]);
            err = VECS[v][8];
            setup = VECS[v][9];
            acc = VECS[v][10];
            if (setup)      tag = "R3";
            else if (err)   tag = "R6";
            else if (!acc)  tag = "R10";
            else if (len == 0) tag = "R11";
            else            tag = "R2";
            for (int i = 0; i < len; i++) send_byte({v[3:0], i[3:0]}, setup);
            send_eop(!err, setup);
            exp_size = acc ? len : last_size;
            chk(tag, "done", rx_done, int'(acc));
            chk(tag, "size", rx_size, exp_size);
            chk(tag, "nak", rx_nak, int'(acc));
            if (acc) begin
                for (int i = 0; i < len; i++) begin
                    read_one(x);
                    chk("R2,R5", "data", x, {v[3:0], i[3:0]});
                end
                read_one(x);
                chk("R8", "empty read", x, 0);
                read_one(x);
                chk("R8", "empty read again", x, 0);
                pulse_done_clr();
                pulse_rel();
                chk("R5", "nak after release", rx_nak, 0);
            end
            last_size = exp_size;
        end

        // R4 traffic while held is dropped
        send_byte(8'h11, 1'b0);
        send_byte(8'h22, 1'b0);
        send_eop(1'b1, 1'b0);
        send_byte(8'h33, 1'b0);
        send_byte(8'h44, 1'b0);
        send_eop(1'b1, 1'b0);
        send_eop(1'b0, 1'b0);
        chk("R4", "size", rx_size, 2);
        chk("R4", "nak", rx_nak, 1);
        chk("R4", "done", rx_done, 1);
        read_one(x); chk("R4", "data0", x, 8'h11);
        read_one(x); chk("R4", "data1", x, 8'h22);
        read_one(x); chk("R4", "data end", x, 0);

        // R7 clearing the flag keeps the lock
        pulse_done_clr();
        chk("R7", "done cleared", rx_done, 0);
        chk("R7", "nak kept", rx_nak, 1);
        pulse_rel();

        // R7 set wins over clear in the same cycle
        send_byte(8'h55, 1'b0);
        rx_eop_ok = 1'b1; done_clr = 1'b1;
        @(negedge clk);
        rx_eop_ok = 1'b0; done_clr = 1'b0;
        chk("R7", "set over clear", rx_done, 1);
        chk("R7", "size", rx_size, 1);
        read_one(x); chk("R7", "data", x, 8'h55);
        pulse_done_clr();
        pulse_rel();

        // R12 byte with end strobe is not stored
        send_byte(8'h61, 1'b0);
        send_byte(8'h62, 1'b0);
        rx_valid = 1'b1; rx_data = 8'h63; rx_eop_ok = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_eop_ok = 1'b0;
        chk("R12", "size", rx_size, 2);
        read_one(x); chk("R12", "data0", x, 8'h61);
        read_one(x); chk("R12", "data1", x, 8'h62);
        read_one(x); chk("R12", "no third", x, 0);
        pulse_done_clr();
        pulse_rel();

        // R9 clear while held
        send_byte(8'h71, 1'b0);
        send_eop(1'b1, 1'b0);
        pulse_clr();
        chk("R9", "nak", rx_nak, 0);
        chk("R9", "size", rx_size, 0);
        chk("R9", "done kept", rx_done, 1);
        read_one(x); chk("R9", "read after clear", x, 0);
        pulse_done_clr();

        // R9 clear during reception restarts at entry 0
        send_byte(8'h72, 1'b0);
        send_byte(8'h73, 1'b0);
        pulse_clr();
        send_byte(8'h74, 1'b0);
        send_eop(1'b1, 1'b0);
        chk("R9", "size restart", rx_size, 1);
        read_one(x); chk("R9", "data restart", x, 8'h74);
        pulse_done_clr();
        pulse_rel();
        chk("R5", "nak released", rx_nak, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule